// File: doc/BRIEF.md
# Serial Setup Port Control Register Bank

This block receives configuration commands for a stereo audio converter over a three-wire serial setup port: a setup clock, a data line and a latch strobe. Each command is a 16-bit word. It carries five reserved bits that must be zero, a 2-bit register address and a 9-bit payload. A well-formed word is stored into one of four 9-bit control registers. The block drives decoded controls for the datapath: attenuation for each channel, mute, zero-detect enable, the de-emphasis rate and the routing of channels to outputs.

A mode input selects where these controls come from. In software mode they come from the register bank. In hardware mode a pair of pins picks the de-emphasis rate and a pin drives mute. All other controls take fixed neutral values. The registers keep their contents in hardware mode and still accept writes. The serial lines are sampled by the system clock, and edges are found by comparing each line with its value at the previous clock.

Top module: `serial_ctrl_regs`

## Requirements
- R1: Bits are captured MSB first, one per rising edge of `sclk_i`. A frame is committed on the rising edge of `latch_i`. Frame bits [15:11] are reserved, [10:9] are the address and [8:0] are the payload. The write is visible on the outputs from the clock edge that detects the latch edge.
- R2: Address 0 selects register 0, 1 selects register 1, 2 selects register 2 and 3 selects register 3. A write changes only the addressed register.
- R3: In software mode, `atten_l_o` equals register 0 bits [7:0] and `atten_r_o` equals register 1 bits [7:0]. Code 0 means 0 dB.
- R4: In software mode, `mute_o` equals register 2 bit 0 and `zero_det_en_o` equals register 2 bit 4. `deemph_o` equals register 2 bits [2:1], with 00 off, 01 32 kHz, 10 44.1 kHz and 11 48 kHz.
- R5: In software mode, register 3 bits [7:4] set the routing. `src_l_o` and `src_r_o` name the channel feeding each output, with 0 for left and 1 for right. Code 0 gives (0,1), code 1 gives (1,0), code 2 gives (0,0) and code 3 gives (1,1). Every other code gives (0,1).
- R6: A frame with any reserved bit set leaves every register unchanged.
- R7: A frame of any bit count other than 16 leaves every register unchanged. A 16-bit frame sent after a rejected frame is accepted.
- R8: After reset every register is 0. This gives 0 dB on both channels, mute off, de-emphasis off, zero detect off and straight routing.
- R9: In hardware mode, `hw_de_i` maps 00 to off, 01 to 48 kHz, 10 to 44.1 kHz and 11 to 32 kHz, using the `deemph_o` encoding of R4.
- R10: In hardware mode, both attenuations are 0, zero detect is off, routing is (0,1) and `mute_o` follows `hw_mute_i`. Registers keep their contents and still accept writes.
- R11: In software mode, `hw_de_i` and `hw_mute_i` have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial setup clock |
| sdat_i | input | 1 | Serial setup data |
| latch_i | input | 1 | Frame commit strobe, acts on its rising edge |
| mode_sw_i | input | 1 | 1 selects software mode, 0 selects hardware mode |
| hw_de_i | input | 2 | Hardware-mode de-emphasis select |
| hw_mute_i | input | 1 | Hardware-mode mute |
| atten_l_o | output | 8 | Left attenuation code |
| atten_r_o | output | 8 | Right attenuation code |
| mute_o | output | 1 | Mute |
| zero_det_en_o | output | 1 | Zero-detect enable |
| deemph_o | output | 2 | De-emphasis rate code |
| src_l_o | output | 1 | Source channel of left output |
| src_r_o | output | 1 | Source channel of right output |

## Verification
The hardest cases to reach are malformed frames. These are frames one bit short, one bit long, or carrying a single reserved bit set at each of the five positions. Each one must leave the register bank exactly as it was. The bench builds these frames by cutting or extending a valid word. Before each one it writes known nonzero contents, so that any stray write shows on the outputs. It also writes registers while in hardware mode and then returns to software mode. This shows that the hidden register state was updated even though the outputs did not move.

// File: rtl/scr_pkg.sv
package scr_pkg;
  localparam int RSV_W   = 5;
  localparam int ADDR_W  = 2;
  localparam int DATA_W  = 9;
  localparam int FRAME_W = RSV_W + ADDR_W + DATA_W;
  localparam int NUM_REGS = 1 << ADDR_W;

  typedef enum logic [1:0] {DE_OFF = 2'd0, DE_32K = 2'd1, DE_44K1 = 2'd2, DE_48K = 2'd3} deemph_e;

  // hardware pin code -> common rate code
  function automatic deemph_e hw_deemph(input logic [1:0] pins);
    case (pins)
      2'b01:   return DE_48K;
      2'b10:   return DE_44K1;
      2'b11:   return DE_32K;
      default: return DE_OFF;
    endcase
  endfunction
endpackage

// File: rtl/scr_shift.sv
module scr_shift #(
  parameter int RSV_W  = 5,
  parameter int ADDR_W = 2,
  parameter int DATA_W = 9,
  localparam int FRAME_W = RSV_W + ADDR_W + DATA_W,
  localparam int CNT_W   = $clog2(FRAME_W + 2)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              sdat_i,
  input  logic              latch_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o
);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(FRAME_W + 1);

  logic               sclk_q, latch_q;
  logic [FRAME_W-1:0] sr_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               sclk_rise, latch_rise;

  assign sclk_rise  = sclk_i & ~sclk_q;
  assign latch_rise = latch_i & ~latch_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q  <= 1'b0;
      latch_q <= 1'b0;
      sr_q    <= '0;
      cnt_q   <= '0;
    end else begin
      sclk_q  <= sclk_i;
      latch_q <= latch_i;
      if (latch_rise) begin
        cnt_q <= '0;
      end else if (sclk_rise) begin
        sr_q <= {sr_q[FRAME_W-2:0], sdat_i};
        // saturate one past full so long frames stay invalid
        if (cnt_q != CNT_OVER) cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign wr_en_o   = latch_rise && (cnt_q == CNT_FULL) &&
                     (sr_q[FRAME_W-1 -: RSV_W] == '0);
  assign wr_addr_o = sr_q[DATA_W +: ADDR_W];
  assign wr_data_o = sr_q[DATA_W-1:0];
endmodule

// File: rtl/scr_bank.sv
module scr_bank #(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 9,
  localparam int NUM_REGS = 1 << ADDR_W
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              wr_en_i,
  input  logic [ADDR_W-1:0]                 wr_addr_i,
  input  logic [DATA_W-1:0]                 wr_data_i,
  output logic [NUM_REGS-1:0][DATA_W-1:0]   regs_o
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic [DATA_W-1:0] r_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                      r_q <= '0;
      else if (wr_en_i && wr_addr_i == ADDR_W'(g))      r_q <= wr_data_i;
    end
    assign regs_o[g] = r_q;
  end
endmodule

// File: rtl/scr_decode.sv
module scr_decode
  import scr_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int NUM_REGS = 4
) (
  input  logic                            mode_sw_i,
  input  logic [1:0]                      hw_de_i,
  input  logic                            hw_mute_i,
  input  logic [NUM_REGS-1:0][DATA_W-1:0] regs_i,
  output logic [7:0]                      atten_l_o,
  output logic [7:0]                      atten_r_o,
  output logic                            mute_o,
  output logic                            zero_det_en_o,
  output logic [1:0]                      deemph_o,
  output logic                            src_l_o,
  output logic                            src_r_o
);
  logic [3:0] route;
  logic       sw_src_l, sw_src_r;

  assign route = regs_i[3][7:4];

  always_comb begin
    case (route)
      4'd1:    begin sw_src_l = 1'b1; sw_src_r = 1'b0; end
      4'd2:    begin sw_src_l = 1'b0; sw_src_r = 1'b0; end
      4'd3:    begin sw_src_l = 1'b1; sw_src_r = 1'b1; end
      default: begin sw_src_l = 1'b0; sw_src_r = 1'b1; end
    endcase
  end

  always_comb begin
    if (mode_sw_i) begin
      atten_l_o     = regs_i[0][7:0];
      atten_r_o     = regs_i[1][7:0];
      mute_o        = regs_i[2][0];
      deemph_o      = regs_i[2][2:1];
      zero_det_en_o = regs_i[2][4];
      src_l_o       = sw_src_l;
      src_r_o       = sw_src_r;
    end else begin
      atten_l_o     = '0;
      atten_r_o     = '0;
      mute_o        = hw_mute_i;
      deemph_o      = hw_deemph(hw_de_i);
      zero_det_en_o = 1'b0;
      src_l_o       = 1'b0;
      src_r_o       = 1'b1;
    end
  end
endmodule

// File: rtl/serial_ctrl_regs.sv
module serial_ctrl_regs
  import scr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sclk_i,
  input  logic       sdat_i,
  input  logic       latch_i,
  input  logic       mode_sw_i,
  input  logic [1:0] hw_de_i,
  input  logic       hw_mute_i,
  output logic [7:0] atten_l_o,
  output logic [7:0] atten_r_o,
  output logic       mute_o,
  output logic       zero_det_en_o,
  output logic [1:0] deemph_o,
  output logic       src_l_o,
  output logic       src_r_o
);
  logic                            wr_en;
  logic [ADDR_W-1:0]               wr_addr;
  logic [DATA_W-1:0]               wr_data;
  logic [NUM_REGS-1:0][DATA_W-1:0] regs;

  scr_shift #(.RSV_W(RSV_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_shift (
    .clk_i, .rst_ni, .sclk_i, .sdat_i, .latch_i,
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data)
  );

  scr_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bank (
    .clk_i, .rst_ni,
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .regs_o(regs)
  );

  scr_decode #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_dec (
    .mode_sw_i, .hw_de_i, .hw_mute_i, .regs_i(regs),
    .atten_l_o, .atten_r_o, .mute_o, .zero_det_en_o, .deemph_o,
    .src_l_o, .src_r_o
  );
endmodule

// File: rtl/scr_checker.sv
module scr_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       latch_i,
  input logic       mode_sw_i,
  input logic       hw_mute_i,
  input logic [7:0] atten_l_o,
  input logic [7:0] atten_r_o,
  input logic       mute_o,
  input logic       zero_det_en_o,
  input logic [1:0] deemph_o,
  input logic       src_l_o,
  input logic       src_r_o
);
  logic latch_seen_q, lrise;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) latch_seen_q <= 1'b0;
    else         latch_seen_q <= latch_i;
  end
  assign lrise = latch_i & ~latch_seen_q;

  // outputs move only on a latch edge while in software mode
  assert_atten_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_sw_i && $past(mode_sw_i) && !$past(lrise)) |->
      ($stable(atten_l_o) && $stable(atten_r_o)));

  assert_ctrl_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_sw_i && $past(mode_sw_i) && !$past(lrise)) |->
      ($stable(mute_o) && $stable(deemph_o) && $stable(zero_det_en_o)));

  assert_hw_fixed_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_sw_i |-> (atten_l_o == 8'd0 && atten_r_o == 8'd0 && !zero_det_en_o
                    && !src_l_o && src_r_o));

  assert_hw_mute_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_sw_i |-> (mute_o == hw_mute_i));

  assert_route_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_sw_i && $past(mode_sw_i) && !$past(lrise)) |->
      ($stable(src_l_o) && $stable(src_r_o)));
endmodule

bind serial_ctrl_regs scr_checker u_chk (
  .clk_i, .rst_ni, .latch_i, .mode_sw_i, .hw_mute_i,
  .atten_l_o, .atten_r_o, .mute_o, .zero_det_en_o, .deemph_o,
  .src_l_o, .src_r_o
);

// File: tb/tb_serial_ctrl_regs.sv
module tb_serial_ctrl_regs;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic sclk = 1'b0, sdat = 1'b0, latch = 1'b0, mode_sw = 1'b1, hw_mute = 1'b0;
  logic [1:0] hw_de = 2'b00;
  logic [7:0] atten_l, atten_r;
  logic mute, zde, src_l, src_r;
  logic [1:0] deemph;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [8:0] mreg [4];

  always #2 clk = ~clk;

  serial_ctrl_regs dut (
    .clk_i(clk), .rst_ni, .sclk_i(sclk), .sdat_i(sdat), .latch_i(latch),
    .mode_sw_i(mode_sw), .hw_de_i(hw_de), .hw_mute_i(hw_mute),
    .atten_l_o(atten_l), .atten_r_o(atten_r), .mute_o(mute),
    .zero_det_en_o(zde), .deemph_o(deemph), .src_l_o(src_l), .src_r_o(src_r)
  );

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // send the low n bits of w, MSB first, then pulse the latch
  task automatic send(input logic [16:0] w, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      sdat = w[i]; sclk = 1'b0; wait_n(2);
      sclk = 1'b1; wait_n(2);
    end
    sclk = 1'b0; wait_n(2);
    latch = 1'b1; wait_n(2);
    latch = 1'b0; wait_n(2);
  endtask

  function automatic logic [16:0] frame(input logic [1:0] a, input logic [8:0] d);
    return {1'b0, 5'b0, a, d};
  endfunction

  task automatic wr(input logic [1:0] a, input logic [8:0] d);
    send(frame(a, d), 16);
    mreg[a] = d;
  endtask

  task automatic cmp(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    int el, er, em, ed, ez, sl, sr;
    if (mode_sw) begin
      el = mreg[0][7:0]; er = mreg[1][7:0]; em = mreg[2][0];
      ed = mreg[2][2:1]; ez = mreg[2][4];
      case (mreg[3][7:4])
        4'd1: begin sl = 1; sr = 0; end
        4'd2: begin sl = 0; sr = 0; end
        4'd3: begin sl = 1; sr = 1; end
        default: begin sl = 0; sr = 1; end
      endcase
    end else begin
      el = 0; er = 0; em = hw_mute; ez = 0; sl = 0; sr = 1;
      ed = (hw_de == 2'd0) ? 0 : 4 - hw_de; // 01->3(48k),10->2,11->1(32k)
    end
    cmp(tag, "atten_l", atten_l, el);
    cmp(tag, "atten_r", atten_r, er);
    cmp(tag, "mute", mute, em);
    cmp(tag, "deemph", deemph, ed);
    cmp(tag, "zero_det", zde, ez);
    cmp(tag, "src_l", src_l, sl);
    cmp(tag, "src_r", src_r, sr);
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [8:0] pats [6];
    pats = '{9'h000, 9'h1FF, 9'h0A5, 9'h15A, 9'h013, 9'h1E6};
    for (int i = 0; i < 4; i++) mreg[i] = '0;
    wait_n(3); rst_ni = 1'b1; wait_n(2);
    check_all("R8");

    // R1 R2 R3 R4: every address with several payloads
    for (int p = 0; p < 6; p++)
      for (int a = 0; a < 4; a++) begin
        wr(2'(a), pats[p]);
        check_all(a < 2 ? "R3" : "R4");
      end
    check_all("R2");

    // R4: de-emphasis, mute and zero-detect fields
    for (int v = 0; v < 32; v++) begin
      wr(2'd2, 9'(v));
      check_all("R4");
    end

    // R5: all routing codes
    for (int c = 0; c < 16; c++) begin
      wr(2'd3, {1'b0, 4'(c), 4'b1010});
      check_all("R5");
    end

    // R6: each reserved bit set alone
    wr(2'd0, 9'h03C); wr(2'd1, 9'h0C3); wr(2'd2, 9'h017); wr(2'd3, 9'h010);
    for (int b = 0; b < 5; b++) begin
      logic [16:0] w;
      w = frame(2'(b % 4), 9'h1FF);
      w[11 + b] = 1'b1;
      send(w, 16);
      check_all("R6");
    end

    // R7: short, long, then recovery
    send(frame(2'd0, 9'h0FF), 15);
    check_all("R7");
    send(frame(2'd1, 9'h0FF), 17);
    check_all("R7");
    send({1'b1, frame(2'd2, 9'h000)}, 17);
    check_all("R7");
    wr(2'd0, 9'h077);
    check_all("R7");
    send(frame(2'd1, 9'h000), 2);
    check_all("R7");

    // R11: pins ignored in software mode
    for (int k = 0; k < 8; k++) begin
      hw_de = 2'(k); hw_mute = k[2]; wait_n(2);
      check_all("R11");
    end

    // R9 R10: hardware mode
    mode_sw = 1'b0;
    for (int k = 0; k < 8; k++) begin
      hw_de = 2'(k); hw_mute = k[2]; wait_n(2);
      check_all(k < 4 ? "R9" : "R10");
    end
    wr(2'd0, 9'h0E1); wr(2'd2, 9'h015); wr(2'd3, 9'h020);
    check_all("R10");
    mode_sw = 1'b1; wait_n(2);
    check_all("R10");

    // R8: reset restores defaults
    rst_ni = 1'b0; wait_n(2);
    for (int i = 0; i < 4; i++) mreg[i] = '0;
    rst_ni = 1'b1; wait_n(2);
    check_all("R8");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule